// File: doc/BRIEF.md
# Few-Inverter Bitwise Complementer

This block is purely combinational. It drives the bitwise complement of its input vector onto its output vector. The only logic it uses is two-input AND and OR gates plus a very small, fixed number of separately instantiated inverter cells. The parameter `WIDTH` selects the variant. A width of 3 uses two inverters and a width of 7 uses three. In general a width of 2^M-1 needs M inverters.

The block does not invert each bit. It counts the high input bits as a population count and forms monotone "at least k inputs are high" summaries from a gate-only threshold network. It then inverts one bit of that count at a time, starting with the most significant bit. Each inverter input is a monotone function of the thresholds and of the inverters already placed above it. Each output bit is then an OR of products. Each product pairs a threshold on the other inputs (every input except the one this output belongs to) with a chosen set of inverted count bits. This lets each output decide whether its own input was low.

There is no clock and no feedback path, and correctness is defined only at steady state. The design has no state machine, so there are no states or transitions to name.

Top module: `fewnot_complement`

## Requirements
- R1: With `WIDTH` = 3, `dout` equals the bitwise complement of `din` for all 8 input patterns.
- R2: With `WIDTH` = 7, `dout` equals the bitwise complement of `din` for all 128 input patterns.
- R3: An all-zero `din` (population count 0) gives an all-ones `dout` in both variants.
- R4: An all-ones `din` (population count equal to `WIDTH`) gives an all-zero `dout` in both variants.
- R5: A `din` with exactly one bit high drives only that bit position low on `dout`, and every other output bit is high.
- R6: A `din` with exactly one bit low drives only that bit position high on `dout`, and every other output bit is low.
- R7: The inverter count is `fewnot_pkg::inv_count(WIDTH)`, which is 2 for width 3 and 3 for width 7. Any other width is rejected at elaboration. Inverter j (j=0 is the least significant) outputs high exactly when bit j of the population count of `din` is 0.
- R8: For every population count from 0 to `WIDTH`, a pattern with that count (the lowest bits set) yields its complement. The internal threshold summaries are monotone: "at least k+1 high" implies "at least k high".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | WIDTH | Input vector to be complemented |
| dout | output | WIDTH | Bitwise complement of `din` |

## Verification
Both variants are driven through every input pattern. This covers every pairing of a population count with each bit position, which is the one thing the selection logic depends on. Focused patterns then isolate the edges of the count range. All-zero is the only case in which every inverter output is high at once. All-ones is the case in which no product term may fire. Single-high and single-low patterns walk across each position and show that an output tells its own bit apart from its neighbours when the counts of "others" differ by one. A ladder of counts from 0 to `WIDTH` crosses each threshold, and therefore each inverted count bit, in turn. It confirms that every count boundary (1, 2, 4 and so on) selects the right product.

// File: rtl/fewnot_pkg.sv
package fewnot_pkg;

    localparam int MAX_BITS  = 3;
    localparam int MAX_TERMS = 8;
    localparam int MASK_W    = MAX_BITS * MAX_TERMS;

    // Number of inverters for a width of 2^M-1; 0 marks an unsupported width.
    function automatic int inv_count(int width);
        for (int m = 2; m <= MAX_BITS; m++) begin
            if (((1 << m) - 1) == width) return m;
        end
        return 0;
    endfunction

    // Flat index of "at least k of the first row inputs high", with 1 <= k <= row.
    function automatic int tri_idx(int row, int k);
        return (row * (row - 1)) / 2 + k - 1;
    endfunction

    // Masks for the feed of the inverter on count bit b.
    // Term p matches the higher count bits equal to p: it needs the inverted
    // count bit j (j > b) wherever p holds a zero.
    function automatic logic [MASK_W-1:0] feed_masks(int bits, int b);
        logic [MASK_W-1:0] m;
        m = '0;
        for (int p = 0; p < (1 << (bits - 1 - b)); p++) begin
            for (int j = b + 1; j < bits; j++) begin
                if (((p >> (j - b - 1)) & 1) == 0) m[p*MAX_BITS + j] = 1'b1;
            end
        end
        return m;
    endfunction

    // Masks for an output: term k needs the inverted count bit j wherever k holds a zero.
    function automatic logic [MASK_W-1:0] out_masks(int bits);
        logic [MASK_W-1:0] m;
        m = '0;
        for (int k = 0; k < (1 << bits) && k < MAX_TERMS; k++) begin
            for (int j = 0; j < bits; j++) begin
                if (((k >> j) & 1) == 0) m[k*MAX_BITS + j] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/fewnot_inv.sv
module fewnot_inv (
    input  logic a,
    output logic y
);
    // The only complement operator in the design: one counted inverter cell.
    assign y = ~a;
endmodule

// File: rtl/fewnot_gate2.sv
module fewnot_gate2 #(
    parameter bit USE_OR = 1'b0
) (
    input  logic a,
    input  logic b,
    output logic y
);
    generate
        if (USE_OR) begin : g_or
            assign y = a | b;
        end else begin : g_and
            assign y = a & b;
        end
    endgenerate
endmodule

// File: rtl/fewnot_atleast.sv
module fewnot_atleast #(
    parameter int N = 3
) (
    input  logic [N-1:0] x,
    output logic [N:1]   ge
);
    localparam int CELLS = (N * (N + 1)) / 2;

    // lvl[tri_idx(i,k)]: at least k of x[i-1:0] are high.
    logic [CELLS-1:0] lvl;

    generate
        for (genvar i = 1; i <= N; i++) begin : g_row
            for (genvar k = 1; k <= i; k++) begin : g_col
                if (i == 1) begin : g_seed
                    assign lvl[fewnot_pkg::tri_idx(1, 1)] = x[0];
                end else if (k == 1) begin : g_any
                    fewnot_gate2 #(.USE_OR(1'b1)) u_or (
                        .a(lvl[fewnot_pkg::tri_idx(i-1, 1)]), .b(x[i-1]),
                        .y(lvl[fewnot_pkg::tri_idx(i, 1)]));
                end else if (k == i) begin : g_all
                    fewnot_gate2 #(.USE_OR(1'b0)) u_and (
                        .a(lvl[fewnot_pkg::tri_idx(i-1, k-1)]), .b(x[i-1]),
                        .y(lvl[fewnot_pkg::tri_idx(i, k)]));
                end else begin : g_mid
                    logic carry;
                    fewnot_gate2 #(.USE_OR(1'b0)) u_and (
                        .a(lvl[fewnot_pkg::tri_idx(i-1, k-1)]), .b(x[i-1]),
                        .y(carry));
                    fewnot_gate2 #(.USE_OR(1'b1)) u_or (
                        .a(lvl[fewnot_pkg::tri_idx(i-1, k)]), .b(carry),
                        .y(lvl[fewnot_pkg::tri_idx(i, k)]));
                end
            end
        end
        for (genvar k = 1; k <= N; k++) begin : g_out
            assign ge[k] = lvl[fewnot_pkg::tri_idx(N, k)];
        end
    endgenerate

    // R8: thresholds are monotone in k.
    always_comb begin
        for (int k = 1; k < N; k++) begin
            a_r8_thresh_monotone: assert (!ge[k+1] || ge[k])
                else $error("threshold %0d set without threshold %0d", k + 1, k);
        end
    end
endmodule

// File: rtl/fewnot_sop.sv
module fewnot_sop #(
    parameter int TERMS = 1,
    parameter int BITS  = 2,
    parameter logic [fewnot_pkg::MASK_W-1:0] MASKS = '0
) (
    input  logic [TERMS-1:0] lit,
    input  logic [BITS-1:0]  sel,
    output logic             y
);
    logic [TERMS-1:0] prod;
    logic [TERMS-1:0] acc;
    logic             unused_sel;

    assign unused_sel = ^sel;

    generate
        for (genvar t = 0; t < TERMS; t++) begin : g_term
            logic [BITS:0] chain;
            assign chain[0] = lit[t];
            for (genvar j = 0; j < BITS; j++) begin : g_fac
                if (MASKS[t*fewnot_pkg::MAX_BITS + j]) begin : g_use
                    fewnot_gate2 #(.USE_OR(1'b0)) u_and (
                        .a(chain[j]), .b(sel[j]), .y(chain[j+1]));
                end else begin : g_skip
                    assign chain[j+1] = chain[j];
                end
            end
            assign prod[t] = chain[BITS];
        end

        assign acc[0] = prod[0];
        for (genvar t = 1; t < TERMS; t++) begin : g_sum
            fewnot_gate2 #(.USE_OR(1'b1)) u_or (
                .a(acc[t-1]), .b(prod[t]), .y(acc[t]));
        end
    endgenerate

    assign y = acc[TERMS-1];

    // R7: the product terms pin down one count prefix, so at most one can be true.
    always_comb begin
        a_r7_one_product: assert ($onehot0(prod))
            else $error("more than one product term active: %b", prod);
    end
endmodule

// File: rtl/fewnot_complement.sv
module fewnot_complement
    import fewnot_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int NINV   = inv_count(WIDTH);
    localparam int CB     = (NINV == 0) ? 2 : NINV;
    localparam int OTHERS = WIDTH - 1;

    logic [WIDTH:1] ge_all;
    logic [CB-1:0]  feed;
    logic [CB-1:0]  nbit;

    generate
        if (NINV == 0) begin : g_bad_width
            $error("fewnot_complement: WIDTH must be 2^M-1 with M in 2..%0d", MAX_BITS);
        end
    endgenerate

    fewnot_atleast #(.N(WIDTH)) u_count (.x(din), .ge(ge_all));

    // One counted inverter per population-count bit, the most significant first.
    generate
        for (genvar b = 0; b < CB; b++) begin : g_bit
            localparam int FT = 1 << (CB - 1 - b);
            logic [FT-1:0] flit;
            for (genvar p = 0; p < FT; p++) begin : g_lit
                assign flit[p] = ge_all[p * (1 << (b + 1)) + (1 << b)];
            end
            fewnot_sop #(.TERMS(FT), .BITS(CB), .MASKS(feed_masks(CB, b))) u_feed (
                .lit(flit), .sel(nbit), .y(feed[b]));
            fewnot_inv u_not (.a(feed[b]), .y(nbit[b]));
        end
    endgenerate

    // Each output: OR over k of (others >= k) AND the inverted count bits that are zero in k.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_out
            logic [OTHERS-1:0] oth;
            logic [OTHERS:1]   oge;
            logic [WIDTH-1:0]  olit;
            for (genvar j = 0; j < OTHERS; j++) begin : g_pick
                assign oth[j] = din[(j < i) ? j : j + 1];
            end
            fewnot_atleast #(.N(OTHERS)) u_oth (.x(oth), .ge(oge));
            assign olit[0] = 1'b1;
            assign olit[WIDTH-1:1] = oge;
            fewnot_sop #(.TERMS(WIDTH), .BITS(CB), .MASKS(out_masks(CB))) u_sel (
                .lit(olit), .sel(nbit), .y(dout[i]));
        end
    endgenerate

    always_comb begin
        // R1 and R2: every output bit differs from its input bit.
        a_r1_complement: assert (&(dout ^ din))
            else $error("output %b is not the complement of %b", dout, din);
        // R7: inverter j is high exactly when count bit j is zero.
        for (int j = 0; j < CB; j++) begin
            a_r7_inv_code: assert (nbit[j] == ((($countones(din) >> j) & 1) == 0))
                else $error("inverter %0d disagrees with count of %b", j, din);
        end
    end
endmodule

// File: tb/fewnot_complement_test.sv
`timescale 1ns/1ps
module fewnot_complement_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [2:0] din3;
    logic [2:0] dout3;
    logic [6:0] din7;
    logic [6:0] dout7;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    fewnot_complement #(.WIDTH(3)) uut_w3 (.din(din3), .dout(dout3));
    fewnot_complement #(.WIDTH(7)) uut    (.din(din7), .dout(dout7));

    task automatic check(string req, logic [6:0] act, logic [6:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic apply(logic [2:0] a3, logic [6:0] a7);
        @(negedge clk);
        din3 = a3;
        din7 = a7;
        @(posedge clk);
        #1;
    endtask

    task automatic t_counts();
        check("R7 width3", 7'(fewnot_pkg::inv_count(3)), 7'd2);
        check("R7 width7", 7'(fewnot_pkg::inv_count(7)), 7'd3);
        check("R7 width5", 7'(fewnot_pkg::inv_count(5)), 7'd0);
    endtask

    task automatic t_after_reset();
        apply(3'b000, 7'b0);
        check("R3 w3 start", {4'b0, dout3}, 7'b0000111);
        check("R3 w7 start", dout7, 7'b1111111);
    endtask

    task automatic t_exhaust3();
        for (int v = 0; v < 8; v++) begin
            apply(3'(v), 7'b0);
            check("R1", {4'b0, dout3}, {4'b0, ~3'(v)});
        end
    endtask

    task automatic t_exhaust7();
        for (int v = 0; v < 128; v++) begin
            apply(3'b0, 7'(v));
            check("R2", dout7, ~7'(v));
        end
    endtask

    task automatic t_all_ones();
        apply(3'b111, 7'h7f);
        check("R4 w3", {4'b0, dout3}, 7'b0);
        check("R4 w7", dout7, 7'b0);
    endtask

    task automatic t_single_high();
        for (int i = 0; i < 7; i++) begin
            apply(3'(1 << (i % 3)), 7'(1 << i));
            check("R5 w3", {4'b0, dout3}, {4'b0, ~3'(1 << (i % 3))});
            check("R5 w7", dout7, ~7'(1 << i));
        end
    endtask

    task automatic t_single_low();
        for (int i = 0; i < 7; i++) begin
            apply(~3'(1 << (i % 3)), ~7'(1 << i));
            check("R6 w3", {4'b0, dout3}, {4'b0, 3'(1 << (i % 3))});
            check("R6 w7", dout7, 7'(1 << i));
        end
    endtask

    task automatic t_ladder();
        for (int c = 0; c <= 7; c++) begin
            logic [6:0] p7;
            logic [2:0] p3;
            p7 = 7'((1 << c) - 1);
            p3 = 3'((1 << ((c > 3) ? 3 : c)) - 1);
            apply(p3, p7);
            check("R8 w7", dout7, ~p7);
            check("R8 w3", {4'b0, dout3}, {4'b0, ~p3});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        din3 = 3'b0;
        din7 = 7'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_counts();
        t_after_reset();
        t_exhaust3();
        t_exhaust7();
        t_all_ones();
        t_single_high();
        t_single_low();
        t_ladder();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule